// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Generator

This block drives two independent pulse-width outputs. Each channel chooses one of four rate strobes, divides it with a 7-bit prescaler and steps a waveform engine on every prescaled tick. The engine holds the output high for a programmed number of ticks, then low for a second programmed number, and repeats. Both counts for a channel are packed into one 32-bit word. A single control word carries every channel's source select, divider, prescaler run gate and output enable.

The rate inputs are single-cycle enables in the `clk` domain, so no clock is ever switched. Software reaches the three registers through a plain write strobe and a combinational read port. There is no polarity bit: an inverted waveform is obtained by exchanging the two counts. Clearing an output enable pulls the output low on the clock edge that stores the write, with no wait for the period to end.

Top module: `pwm2_core`

## Requirements
- R1: While `rst` is high and after it falls, every register reads as zero and both `pwm_o` bits are low.
- R2: Byte offset 0x0 holds channel 0's period word and 0x4 holds channel 1's. The high count is in bits [31:16] and the low count in bits [15:0]. A read returns the stored word. Offset 0xC and any offset with `bus_addr[1:0]` nonzero read as zero, and writes to them change nothing.
- R3: Offset 0x8 is the control word. For channel c, bit c is the output enable, bits [4+2c +: 2] are the source select, bits [8+8c +: 7] are the divider and bit 15+8c is the prescaler run gate. Bits 2, 3 and 24-31 read as zero, and writes to them are ignored.
- R4: With the selected strobe high every cycle and divider D, an enabled channel repeats a high run of hi*(D+1) cycles followed by a low run of lo*(D+1) cycles.
- R5: Only the strobe chosen by the source select advances a channel. Activity on the other three strobes has no effect, and a silent selected strobe freezes the output.
- R6: With the run gate cleared, the prescaler produces no ticks and the output holds its level.
- R7: Clearing an output enable makes that output low in the cycle after the write edge. Setting it again starts a fresh high phase, with the output high one cycle after the write is stored.
- R8: A zero low count with a nonzero high count gives a constant high output. A zero high count gives a constant low output.
- R9: The period word is sampled when a high phase starts. A rewrite during a high phase leaves the current high run and the following low run at their old lengths, and the next high run uses the new value.
- R10: The two channels run independently. Disabling or reprogramming one does not disturb the other's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_i | input | 4 | Four rate strobes a channel may select |
| pwm_o | output | 2 | Channel outputs, bit c for channel c |

## Verification
Two events can land in the same cycle: an output-enable write and the prescaled tick that ends a phase, or a period rewrite and the reload at the start of a high phase. The bench clears the enable at arbitrary points inside a long high run while the other channel keeps toggling. It then checks that the output is low at the next sample, stays low, and restarts high on re-enable. A period rewrite issued in the middle of a high run is judged by measuring the current high run, the next low run and the next high run against the old and new counts.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 7;
    localparam int SEL_W  = 2;
    localparam int N_SRC  = 1 << SEL_W;
    localparam int N_CH   = 2;
    localparam int WORD_W = 32;

    // field layout of the control word (decoded per channel)
    localparam int EN_LSB   = 0;
    localparam int SEL_LSB  = 4;
    localparam int DIV_LSB  = 8;
    localparam int CKE_LSB  = 15;
    localparam int DIV_STEP = 8;
    localparam logic [WORD_W-1:0] CTL_MASK = 32'h00FF_FFF3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [N_CH-1:0][WORD_W-1:0] per;
        logic [WORD_W-1:0]           ctl;
    } regs_t;
endpackage

// File: rtl/pwm2_prescale.sv
module pwm2_prescale #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             src_tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d  = pre_q;
        tick_o = 1'b0;
        if (!run_i) begin
            pre_d = '0;
        end else if (src_tick_i) begin
            if (pre_q >= div_i) begin
                pre_d  = '0;
                tick_o = 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    // R6: a stopped prescaler is held at zero
    p_halt_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (pre_q == '0));
    // R5: no strobe, no tick
    p_no_strobe_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
        !src_tick_i |-> !tick_o);
endmodule

// File: rtl/pwm2_wave.sv
module pwm2_wave
    import pwm2_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    output logic         out_o
);
    typedef struct packed {
        phase_e       ph;
        logic [W-1:0] cnt;
        logic [W-1:0] lo;
    } wave_t;

    wave_t st_d, st_q;
    logic  load;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (!en_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: load = 1'b1;
                PH_HIGH: if (tick_i) begin
                    if (st_q.cnt == W'(1)) begin
                        if (st_q.lo != '0) begin
                            st_d.ph  = PH_LOW;
                            st_d.cnt = st_q.lo;
                        end else begin
                            load = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_LOW: if (tick_i) begin
                    if (st_q.cnt == W'(1)) load = 1'b1;
                    else                   st_d.cnt = st_q.cnt - 1'b1;
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
        if (load) begin
            st_d.lo = lo_i;
            if (hi_i != '0) begin
                st_d.ph  = PH_HIGH;
                st_d.cnt = hi_i;
            end else if (lo_i != '0) begin
                st_d.ph  = PH_LOW;
                st_d.cnt = lo_i;
            end else begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ph: PH_IDLE, cnt: '0, lo: '0};
        else     st_q <= st_d;
    end

    assign out_o = (st_q.ph == PH_HIGH);

    // R4: an active phase always has ticks left to run
    p_cnt_live_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != PH_IDLE) |-> (st_q.cnt != '0));
    // R7: a disabled channel returns to idle
    p_idle_after_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (st_q.ph == PH_IDLE));
    // R6: without a tick a running phase does not move
    p_hold_without_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (en_i && !tick_i && st_q.ph != PH_IDLE) |=> ($stable(st_q.cnt) && $stable(st_q.ph)));
endmodule

// File: rtl/pwm2_core.sv
module pwm2_core
    import pwm2_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [N_SRC-1:0]    src_i,
    output logic [N_CH-1:0]     pwm_o
);
    regs_t      regs_d, regs_q;
    logic       aligned;
    logic [1:0] word;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[3:2];

    always_comb begin
        regs_d = regs_q;
        if (bus_wr && aligned) begin
            unique case (word)
                2'd0:    regs_d.per[0] = bus_wdata;
                2'd1:    regs_d.per[1] = bus_wdata;
                2'd2:    regs_d.ctl    = bus_wdata & CTL_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (word)
                2'd0:    bus_rdata = regs_q.per[0];
                2'd1:    bus_rdata = regs_q.per[1];
                2'd2:    bus_rdata = regs_q.ctl;
                default: bus_rdata = '0;
            endcase
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int SEL_POS = SEL_LSB + SEL_W * c;
        localparam int DIV_POS = DIV_LSB + DIV_STEP * c;
        localparam int CKE_POS = CKE_LSB + DIV_STEP * c;

        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
        logic             run, en, src_tick, tick, wave;

        assign sel      = regs_q.ctl[SEL_POS +: SEL_W];
        assign div      = regs_q.ctl[DIV_POS +: DIV_W];
        assign run      = regs_q.ctl[CKE_POS];
        assign en       = regs_q.ctl[EN_LSB + c];
        assign src_tick = src_i[sel];

        pwm2_prescale #(.DIV_W(DIV_W)) u_pre (
            .clk        (clk),
            .rst        (rst),
            .run_i      (run),
            .src_tick_i (src_tick),
            .div_i      (div),
            .tick_o     (tick)
        );

        pwm2_wave #(.W(CNT_W)) u_wave (
            .clk    (clk),
            .rst    (rst),
            .en_i   (en),
            .tick_i (tick),
            .hi_i   (regs_q.per[c][WORD_W-1 -: CNT_W]),
            .lo_i   (regs_q.per[c][CNT_W-1:0]),
            .out_o  (wave)
        );

        // output gate so a cleared enable acts without waiting on the engine
        assign pwm_o[c] = wave & en;
    end

    // R3: reserved control bits never hold a one
    p_unused_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (regs_q.ctl & ~CTL_MASK) == '0);
    // R2: a misaligned write leaves every register untouched
    p_misaligned_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !aligned) |=> $stable(regs_q));
    // R1: both outputs are low in the cycle after reset
    p_reset_low_r1: assert property (@(posedge clk)
        $fell(rst) |-> (pwm_o == '0));
endmodule

// File: tb/pwm2_core_tb_top.sv
module pwm2_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_i = 4'd0;
    logic [1:0]  pwm_o;

    logic [3:0]  hold_mask = 4'd0;
    logic [3:0]  quiet_mask = 4'd0;
    logic [31:0] ctl_sh = 32'd0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pwm2_core dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i), .pwm_o(pwm_o)
    );

    always @(negedge clk)
        src_i <= (4'($urandom) & ~hold_mask & ~quiet_mask) | hold_mask;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_ch(input int c, input bit en, input int sel, input int dv, input bit cke);
        ctl_sh[c] = en;
        ctl_sh[4 + 2*c +: 2] = 2'(sel);
        ctl_sh[8 + 8*c +: 7] = 7'(dv);
        ctl_sh[15 + 8*c] = cke;
        wr(4'h8, ctl_sh);
    endtask

    task automatic wait_lvl(input int c, input bit lvl);
        int n = 0;
        while (pwm_o[c] !== lvl && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic measure(input int c, output int hl, output int ll);
        wait_lvl(c, 1'b0);
        wait_lvl(c, 1'b1);
        hl = 0;
        while (pwm_o[c] === 1'b1 && hl < 5000) begin @(negedge clk); hl++; end
        ll = 0;
        while (pwm_o[c] === 1'b0 && ll < 5000) begin @(negedge clk); ll++; end
    endtask

    // constant-level check over a window
    task automatic hold_check(input int c, input bit lvl, input string tag);
        int bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pwm_o[c] !== lvl) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    function automatic logic [31:0] pword(input int hi, input int lo);
        return {16'(hi), 16'(lo)};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hl, ll, hl2, bt, ah;
        bit prev_b;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(pwm_o == 2'b00, "R1 outputs in reset", pwm_o, 0);
        rst = 1'b0;
        rd(4'h0, d); chk(d == 0, "R1 period0 after reset", d, 0);
        rd(4'h4, d); chk(d == 0, "R1 period1 after reset", d, 0);
        rd(4'h8, d); chk(d == 0, "R1 control after reset", d, 0);
        chk(pwm_o == 2'b00, "R1 outputs after reset", pwm_o, 0);

        // R2: map and readback, holes read zero, misaligned ignored
        wr(4'h0, 32'hDEAD_BEEF); rd(4'h0, d); chk(d == 32'hDEAD_BEEF, "R2 period0 readback", d, 32'hDEAD_BEEF);
        wr(4'h4, 32'h1234_5678); rd(4'h4, d); chk(d == 32'h1234_5678, "R2 period1 readback", d, 32'h1234_5678);
        wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); chk(d == 0, "R2 hole reads zero", d, 0);
        wr(4'h1, 32'h0000_0001); rd(4'h0, d); chk(d == 32'hDEAD_BEEF, "R2 misaligned write ignored", d, 32'hDEAD_BEEF);
        rd(4'h2, d); chk(d == 0, "R2 misaligned read zero", d, 0);
        // R3: reserved control bits
        wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, d); chk(d == 32'h00FF_FFF3, "R3 control mask", d, 32'h00FF_FFF3);
        wr(4'h8, 32'h0); ctl_sh = 0;
        wr(4'h0, 0); wr(4'h4, 0);

        // R4/R5: random configurations, unselected strobes toggle randomly
        for (int it = 0; it < 8; it++) begin
            int c  = $urandom_range(0, 1);
            int s  = $urandom_range(0, 3);
            int dv = $urandom_range(0, 3);
            int h  = $urandom_range(1, 12);
            int l  = $urandom_range(1, 12);
            hold_mask = 4'b1 << s;
            wr(4'(4*c), pword(h, l));
            set_ch(c, 1'b1, s, dv, 1'b1);
            measure(c, hl, ll);
            measure(c, hl, ll);
            chk(hl == h*(dv+1), "R4 R5 high run", hl, h*(dv+1));
            chk(ll == l*(dv+1), "R4 R5 low run", ll, l*(dv+1));
            set_ch(c, 1'b0, s, dv, 1'b0);
        end

        // R5: silent selected strobe freezes output
        hold_mask = 4'b0001; quiet_mask = 4'b0;
        wr(4'h0, pword(3, 3));
        set_ch(0, 1'b1, 0, 0, 1'b1);
        wait_lvl(0, 1'b1);
        hold_mask = 4'b0; quiet_mask = 4'b0001;
        repeat (3) @(negedge clk);
        hold_check(0, 1'b1, "R5 silent source holds");
        quiet_mask = 4'b0; hold_mask = 4'b0001;

        // R6: run gate cleared holds level
        wait_lvl(0, 1'b0);
        set_ch(0, 1'b1, 0, 0, 1'b0);
        hold_check(0, 1'b0, "R6 gate off holds low");
        set_ch(0, 1'b1, 0, 0, 1'b1);
        measure(0, hl, ll);
        chk(hl == 3 && ll == 3, "R6 resumes after gate on", hl*100+ll, 303);

        // R8: zero counts
        wr(4'h0, pword(5, 0));
        repeat (20) @(negedge clk);
        hold_check(0, 1'b1, "R8 zero low gives constant high");
        wr(4'h0, pword(0, 7));
        repeat (20) @(negedge clk);
        hold_check(0, 1'b0, "R8 zero high gives constant low");

        // R9: rewrite during a high run
        wr(4'h0, pword(10, 6));
        measure(0, hl, ll);
        wait_lvl(0, 1'b0);
        wait_lvl(0, 1'b1);
        hl = 0;
        while (pwm_o[0] === 1'b1 && hl < 5000) begin
            if (hl == 3) begin bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = pword(4, 15); end
            else bus_wr = 1'b0;
            @(negedge clk); hl++;
        end
        bus_wr = 1'b0;
        ll = 0;
        while (pwm_o[0] === 1'b0 && ll < 5000) begin @(negedge clk); ll++; end
        hl2 = 0;
        while (pwm_o[0] === 1'b1 && hl2 < 5000) begin @(negedge clk); hl2++; end
        chk(hl == 10, "R9 current high keeps old count", hl, 10);
        chk(ll == 6, "R9 following low keeps old count", ll, 6);
        chk(hl2 == 4, "R9 next high uses new count", hl2, 4);

        // R7/R10: disable mid-high while channel 1 runs
        hold_mask = 4'b0101;
        wr(4'h0, pword(50, 5));
        wr(4'h4, pword(3, 3));
        set_ch(1, 1'b1, 2, 0, 1'b1);
        wait_lvl(0, 1'b0);
        wait_lvl(0, 1'b1);
        repeat (5) @(negedge clk);
        ctl_sh[0] = 1'b0;
        wr(4'h8, ctl_sh);
        chk(pwm_o[0] == 1'b0, "R7 output low right after disable", pwm_o[0], 0);
        ah = 0; bt = 0; prev_b = pwm_o[1];
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_o[0] !== 1'b0) ah++;
            if (pwm_o[1] !== prev_b) bt++;
            prev_b = pwm_o[1];
        end
        chk(ah == 0, "R7 output stays low while disabled", ah, 0);
        chk(bt >= 20, "R10 other channel keeps toggling", bt, 20);
        measure(1, hl, ll);
        chk(hl == 3 && ll == 3, "R10 other channel timing intact", hl*100+ll, 303);
        ctl_sh[0] = 1'b1;
        wr(4'h8, ctl_sh);
        @(negedge clk);
        chk(pwm_o[0] == 1'b1, "R7 re-enable starts high", pwm_o[0], 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule